// File: doc/BRIEF.md
# System Configuration Register Block

This block is a 32-bit register-bus peripheral that occupies a 4 KB address window. It holds two general configuration words, the low byte of the second of which drives eight LED outputs. It also returns read-only identity and board words fixed by parameters, and reports the lock state of eight clock loops under a writable lock mask.

Its main feature is a command channel. Software places a value in the data-out word, then writes the control word with the start bit set. The control word selects a function code and a device index. The transfer completes at the same clock edge. It either writes the data-out word into one of a small bank of oscillator frequency registers, or copies one of those registers into the data-return word. Two status flags record that the command finished and whether its address was legal. An access to an offset with no register behind it reads zero, changes nothing and raises a one-cycle error pulse.

Bus access is single-cycle. Writes take effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is valid combinationally during the same cycle. Byte offset bits [1:0] are ignored.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, the following values hold:
  - Both configuration words, the data-out word, the data-return word and the status word read 0.
  - The control word reads 0x00100000 and the lock mask is 0xFF.
  - The oscillator registers hold their parameter values (defaults 50000000, 24576000 and 25000000).
- R2: A write to the control word (offset 0x0A8) clears the status word (offset 0x0AC). The stored control value equals the written value ANDed with 0x43F00FFF, so the reserved bits [19:12] and [29:26] and the start bit [31] read back as zero.
- R3: The control word is decoded as follows:
  - Device index is bits [11:0], function code is bits [25:20], the write flag is bit 30 and start is bit 31.
  - A control write with start set makes status bit 0 (done) read 1 from the next cycle.
  - Status bit 1 (error) reads 1 when the function code is not 1 or the device index is not below the oscillator count.
- R4: A legal command with the write flag set copies the data-out word (offset 0x0A4) into the selected oscillator register. An illegal one changes no oscillator register.
- R5: A legal command with the write flag clear loads the data-return word (offset 0x0A0) from the selected oscillator register. An illegal read leaves the data-return word unchanged.
- R6: The lock word at offset 0x100 is laid out as follows:
  - Bits [31:24] hold the mask and are the only writable bits.
  - Bits [23:16] show the `loop_locked` inputs and bits [15:1] read 0.
  - Bit 0 reads 1 exactly when every loop whose mask bit is 1 is locked, so it reads 1 when the mask is zero.
- R7: The read-only words are fixed, and writes to them or to the data-return and status words are ignored:
  - Offset 0x00C reads 0.
  - Offset 0x010 reads `BOARD_WORD`.
  - Offsets 0xFF8 and 0xFFC read `AUX_ID` and `PART_ID`.
- R8: `led` always equals bits [7:0] of the configuration word at offset 0x004, which is fully read/write.
- R9: An access to any other offset behaves as follows:
  - A read returns 0 and a write changes no register.
  - `bus_err` is high for exactly the one cycle after the access.
  - `bus_err` is low after any mapped access and in idle cycles.
- R10: The configuration word at offset 0x000 and the data-out word are fully read/write 32-bit registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | One-cycle pulse after an unmapped access |
| loop_locked | input | 8 | Per-loop lock indications |
| led | output | 8 | LED drive |

## Verification
The properties assume the following about the bus:
- Each access lasts one cycle.
- `bus_wr` and `bus_addr` are meaningful only while `bus_sel` is high.
- `loop_locked` changes only between clock edges, never within the cycle in which it is sampled.

The bench drives every bus field at the falling edge and holds it for one full cycle. It returns `bus_sel` low between accesses and changes `loop_locked` only while the bus is idle. Because of this, each command and each lock-word read sees one stable set of inputs.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 12;
    localparam int LOOP_N = 8;

    // Word offsets (byte offset >> 2); software depends on these values.
    localparam logic [9:0] W_CFG_A  = 10'h000;
    localparam logic [9:0] W_CFG_B  = 10'h001;
    localparam logic [9:0] W_SWITCH = 10'h003;
    localparam logic [9:0] W_BOARD  = 10'h004;
    localparam logic [9:0] W_RETURN = 10'h028;
    localparam logic [9:0] W_OUTBOX = 10'h029;
    localparam logic [9:0] W_CMD    = 10'h02A;
    localparam logic [9:0] W_STAT   = 10'h02B;
    localparam logic [9:0] W_LOCK   = 10'h040;
    localparam logic [9:0] W_AUXID  = 10'h3FE;
    localparam logic [9:0] W_PARTID = 10'h3FF;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CFG_A,
        SEL_CFG_B,
        SEL_SWITCH,
        SEL_BOARD,
        SEL_RETURN,
        SEL_OUTBOX,
        SEL_CMD,
        SEL_STAT,
        SEL_LOCK,
        SEL_AUXID,
        SEL_PARTID
    } reg_sel_e;

    typedef struct packed {
        logic        start;
        logic        write;
        logic [3:0]  rsv_hi;
        logic [5:0]  func;
        logic [7:0]  rsv_lo;
        logic [11:0] dev;
    } cmd_word_t;

    typedef struct packed {
        logic err;
        logic done;
    } cmd_stat_t;

    localparam logic [WORD_W-1:0] CMD_KEEP  = 32'h43F0_0FFF;
    localparam logic [WORD_W-1:0] CMD_RESET = 32'h0010_0000;
    localparam logic [5:0]        OSC_FUNC  = 6'd1;

    function automatic reg_sel_e decode_word(input logic [9:0] w);
        case (w)
            W_CFG_A:  return SEL_CFG_A;
            W_CFG_B:  return SEL_CFG_B;
            W_SWITCH: return SEL_SWITCH;
            W_BOARD:  return SEL_BOARD;
            W_RETURN: return SEL_RETURN;
            W_OUTBOX: return SEL_OUTBOX;
            W_CMD:    return SEL_CMD;
            W_STAT:   return SEL_STAT;
            W_LOCK:   return SEL_LOCK;
            W_AUXID:  return SEL_AUXID;
            W_PARTID: return SEL_PARTID;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_osc_bank.sv
module sysctl_osc_bank
    import sysctl_pkg::*;
#(
    parameter int                     N_OSC    = 3,
    parameter logic [32*N_OSC-1:0]    OSC_INIT = {32'd25000000, 32'd24576000, 32'd50000000},
    localparam int                    IDX_W    = (N_OSC > 1) ? $clog2(N_OSC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] osc_q [N_OSC];

    for (genvar i = 0; i < N_OSC; i++) begin : g_osc
        always_ff @(posedge clk) begin
            if (rst) begin
                osc_q[i] <= OSC_INIT[i*32 +: 32];
            end else if (we && idx == IDX_W'(i)) begin
                osc_q[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_OSC; i++) begin
            if (idx == IDX_W'(i)) rdata = osc_q[i];
        end
    end

endmodule

// File: rtl/sysctl_cmd_engine.sv
module sysctl_cmd_engine
    import sysctl_pkg::*;
#(
    parameter int                  N_OSC    = 3,
    parameter logic [32*N_OSC-1:0] OSC_INIT = {32'd25000000, 32'd24576000, 32'd50000000}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic              outbox_we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] cmd_q,
    output cmd_stat_t         stat_q,
    output logic [WORD_W-1:0] return_q,
    output logic [WORD_W-1:0] outbox_q
);

    localparam int IDX_W = (N_OSC > 1) ? $clog2(N_OSC) : 1;

    cmd_word_t         cmd_in;
    logic              addr_ok;
    logic              osc_we;
    logic [WORD_W-1:0] osc_rd;

    assign cmd_in  = cmd_word_t'(wdata);
    assign addr_ok = (cmd_in.func == OSC_FUNC) && (32'(cmd_in.dev) < 32'(N_OSC));
    assign osc_we  = cmd_we && cmd_in.start && cmd_in.write && addr_ok;

    sysctl_osc_bank #(
        .N_OSC    (N_OSC),
        .OSC_INIT (OSC_INIT)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (osc_we),
        .idx   (cmd_in.dev[IDX_W-1:0]),
        .wdata (outbox_q),
        .rdata (osc_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= CMD_RESET;
            stat_q   <= '0;
            return_q <= '0;
            outbox_q <= '0;
        end else begin
            if (outbox_we) outbox_q <= wdata;
            if (cmd_we) begin
                cmd_q  <= wdata & CMD_KEEP;
                stat_q <= '0;
                if (cmd_in.start) begin
                    stat_q.done <= 1'b1;
                    stat_q.err  <= !addr_ok;
                    if (!cmd_in.write && addr_ok) return_q <= osc_rd;
                end
            end
        end
    end

endmodule

// File: rtl/sysctl_lock_agg.sv
module sysctl_lock_agg
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic [LOOP_N-1:0] mask_in,
    input  logic [LOOP_N-1:0] loop_locked,
    output logic [WORD_W-1:0] lock_word
);

    localparam int PAD_W = WORD_W - 2*LOOP_N - 1;

    logic [LOOP_N-1:0] mask_q;
    logic              all_ok;

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '1;
        else if (mask_we) mask_q <= mask_in;
    end

    // 1 when every selected loop reports lock; vacuously 1 for an empty mask.
    assign all_ok    = &(~mask_q | loop_locked);
    assign lock_word = {mask_q, loop_locked, {PAD_W{1'b0}}, all_ok};

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int                  N_OSC      = 3,
    parameter logic [32*N_OSC-1:0] OSC_INIT   = {32'd25000000, 32'd24576000, 32'd50000000},
    parameter logic [31:0]         BOARD_WORD = 32'h0000_0000,
    parameter logic [31:0]         AUX_ID     = 32'h0000_0000,
    parameter logic [31:0]         PART_ID    = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_err,
    input  logic [7:0]  loop_locked,
    output logic [7:0]  led
);

    reg_sel_e          sel;
    logic              wr_hit;
    logic [WORD_W-1:0] cfg_a_q;
    logic [WORD_W-1:0] cfg_b_q;
    logic [WORD_W-1:0] cmd_q;
    cmd_stat_t         stat_q;
    logic [WORD_W-1:0] return_q;
    logic [WORD_W-1:0] outbox_q;
    logic [WORD_W-1:0] lock_word;
    logic              err_q;

    assign sel    = decode_word(bus_addr[ADDR_W-1:2]);
    assign wr_hit = bus_sel && bus_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_a_q <= '0;
            cfg_b_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (wr_hit && sel == SEL_CFG_A) cfg_a_q <= bus_wdata;
            if (wr_hit && sel == SEL_CFG_B) cfg_b_q <= bus_wdata;
            err_q <= bus_sel && (sel == SEL_NONE);
        end
    end

    sysctl_cmd_engine #(
        .N_OSC    (N_OSC),
        .OSC_INIT (OSC_INIT)
    ) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .cmd_we    (wr_hit && sel == SEL_CMD),
        .outbox_we (wr_hit && sel == SEL_OUTBOX),
        .wdata     (bus_wdata),
        .cmd_q     (cmd_q),
        .stat_q    (stat_q),
        .return_q  (return_q),
        .outbox_q  (outbox_q)
    );

    sysctl_lock_agg u_lock (
        .clk         (clk),
        .rst         (rst),
        .mask_we     (wr_hit && sel == SEL_LOCK),
        .mask_in     (bus_wdata[WORD_W-1 -: LOOP_N]),
        .loop_locked (loop_locked),
        .lock_word   (lock_word)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (sel)
                SEL_CFG_A:  bus_rdata = cfg_a_q;
                SEL_CFG_B:  bus_rdata = cfg_b_q;
                SEL_BOARD:  bus_rdata = BOARD_WORD;
                SEL_RETURN: bus_rdata = return_q;
                SEL_OUTBOX: bus_rdata = outbox_q;
                SEL_CMD:    bus_rdata = cmd_q;
                SEL_STAT:   bus_rdata = {{(WORD_W-2){1'b0}}, stat_q};
                SEL_LOCK:   bus_rdata = lock_word;
                SEL_AUXID:  bus_rdata = AUX_ID;
                SEL_PARTID: bus_rdata = PART_ID;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign bus_err = err_q;
    assign led     = cfg_b_q[7:0];

endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        bus_err,
    input logic [7:0]  led,
    input logic [31:0] cmd_q,
    input logic [1:0]  stat_q,
    input logic [31:0] return_q
);

    logic mapped;
    logic cmd_wr;
    logic cfgb_wr;
    logic lock_rd;

    always_comb begin
        case (bus_addr[11:2])
            10'h000, 10'h001, 10'h003, 10'h004, 10'h028, 10'h029,
            10'h02A, 10'h02B, 10'h040, 10'h3FE, 10'h3FF: mapped = 1'b1;
            default: mapped = 1'b0;
        endcase
    end

    assign cmd_wr  = bus_sel && bus_wr && bus_addr[11:2] == 10'h02A;
    assign cfgb_wr = bus_sel && bus_wr && bus_addr[11:2] == 10'h001;
    assign lock_rd = bus_sel && !bus_wr && bus_addr[11:2] == 10'h040;

    // R3
    start_done_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && bus_wdata[31]) |=> stat_q[0]);

    // R2
    status_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !bus_wdata[31]) |=> (stat_q == 2'b00));

    // R2
    cmd_store_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> (cmd_q == ($past(bus_wdata) & 32'h43F0_0FFF)));

    // R5
    bad_read_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && bus_wdata[31] && !bus_wdata[30] && bus_wdata[25:20] != 6'd1)
        |=> $stable(return_q));

    // R9
    unmapped_err_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !mapped) |=> bus_err);

    // R9
    mapped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !mapped) |=> !bus_err);

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && !mapped) |-> (bus_rdata == 32'h0));

    // R8
    led_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfgb_wr |=> $stable(led));

    // R6
    lock_agg_chk: assert property (@(posedge clk) disable iff (rst)
        lock_rd |-> (bus_rdata[0] == &(~bus_rdata[31:24] | bus_rdata[23:16])));

endmodule

bind sysctl_regs sysctl_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .led       (led),
    .cmd_q     (cmd_q),
    .stat_q    (stat_q),
    .return_q  (return_q)
);

// File: tb/sysctl_regs_bench.sv
`timescale 1ns/1ps
module sysctl_regs_bench;

    localparam logic [31:0] BOARD = 32'h0000_0C4F;
    localparam logic [31:0] AUX   = 32'h0123_4567;
    localparam logic [31:0] PART  = 32'h4100_0385;

    localparam logic [11:0] A_CFGA = 12'h000, A_CFGB = 12'h004, A_SW = 12'h00C,
                            A_BRD = 12'h010, A_RET = 12'h0A0, A_OUT = 12'h0A4,
                            A_CMD = 12'h0A8, A_STAT = 12'h0AC, A_LOCK = 12'h100,
                            A_AUX = 12'hFF8, A_PART = 12'hFFC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [7:0]  loop_locked = 8'hFF;
    logic [7:0]  led;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sysctl_regs #(
        .BOARD_WORD (BOARD),
        .AUX_ID     (AUX),
        .PART_ID    (PART)
    ) u_sysctl_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_err     (bus_err),
        .loop_locked (loop_locked),
        .led         (led)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic osc_read(input logic [11:0] dev, input logic [31:0] exp);
        wr(A_CMD, 32'h8010_0000 | 32'(dev));
        rd_chk("R5 osc read status", A_STAT, 32'h1);
        rd_chk("R5 osc read value", A_RET, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 cfg_a reset", A_CFGA, 32'h0);
        rd_chk("R1 cfg_b reset", A_CFGB, 32'h0);
        rd_chk("R1 cmd reset", A_CMD, 32'h0010_0000);
        rd_chk("R1 stat reset", A_STAT, 32'h0);
        rd_chk("R1 return reset", A_RET, 32'h0);
        rd_chk("R1 outbox reset", A_OUT, 32'h0);
        rd_chk("R1 lock reset", A_LOCK, 32'hFFFF_0001);
        chk("R1 led reset", 32'(led), 32'h0);
    endtask

    task automatic t_read_only;
        rd_chk("R7 switch zero", A_SW, 32'h0);
        rd_chk("R7 board", A_BRD, BOARD);
        rd_chk("R7 aux id", A_AUX, AUX);
        rd_chk("R7 part id", A_PART, PART);
        wr(A_SW, 32'hFFFF_FFFF);
        wr(A_BRD, 32'hFFFF_FFFF);
        wr(A_AUX, 32'hFFFF_FFFF);
        wr(A_PART, 32'hFFFF_FFFF);
        wr(A_RET, 32'hFFFF_FFFF);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd_chk("R7 switch after write", A_SW, 32'h0);
        rd_chk("R7 board after write", A_BRD, BOARD);
        rd_chk("R7 aux after write", A_AUX, AUX);
        rd_chk("R7 part after write", A_PART, PART);
        rd_chk("R7 return after write", A_RET, 32'h0);
        rd_chk("R7 stat after write", A_STAT, 32'h0);
    endtask

    task automatic t_rw_words;
        wr(A_CFGA, 32'hDEAD_BEEF);
        rd_chk("R10 cfg_a rw", A_CFGA, 32'hDEAD_BEEF);
        wr(A_CFGB, 32'hA5A5_00C3);
        rd_chk("R8 cfg_b rw", A_CFGB, 32'hA5A5_00C3);
        chk("R8 led follows", 32'(led), 32'hC3);
        wr(A_CFGB, 32'h0000_0018);
        chk("R8 led update", 32'(led), 32'h18);
    endtask

    task automatic t_osc_reads;
        osc_read(12'd0, 32'd50000000);
        osc_read(12'd1, 32'd24576000);
        osc_read(12'd2, 32'd25000000);
    endtask

    task automatic t_cmd_word;
        wr(A_CMD, 32'hFFFF_FFFF);
        rd_chk("R3 all-ones status done+err", A_STAT, 32'h3);
        rd_chk("R2 stored mask", A_CMD, 32'h43F0_0FFF);
        wr(A_CMD, 32'h0010_0001);
        rd_chk("R2 status cleared", A_STAT, 32'h0);
        rd_chk("R2 stored plain", A_CMD, 32'h0010_0001);
    endtask

    task automatic t_osc_write;
        wr(A_OUT, 32'h1234_5678);
        rd_chk("R10 outbox rw", A_OUT, 32'h1234_5678);
        wr(A_CMD, 32'hC010_0001);
        rd_chk("R4 write status", A_STAT, 32'h1);
        osc_read(12'd1, 32'h1234_5678);
    endtask

    task automatic t_bad_cmds;
        wr(A_CMD, 32'h8020_0000);
        rd_chk("R3 bad function err", A_STAT, 32'h3);
        rd_chk("R5 bad read keeps return", A_RET, 32'h1234_5678);
        wr(A_CMD, 32'h8010_0003);
        rd_chk("R3 bad device err", A_STAT, 32'h3);
        rd_chk("R5 bad dev keeps return", A_RET, 32'h1234_5678);
        wr(A_OUT, 32'h0000_DEAD);
        wr(A_CMD, 32'hC010_0003);
        rd_chk("R3 bad write err", A_STAT, 32'h3);
        wr(A_CMD, 32'hC000_0000);
        rd_chk("R3 func0 write err", A_STAT, 32'h3);
        osc_read(12'd0, 32'd50000000);
        osc_read(12'd1, 32'h1234_5678);
        osc_read(12'd2, 32'd25000000);
    endtask

    task automatic t_lock;
        wr(A_LOCK, 32'h0FFF_FFFE);
        loop_locked = 8'h0F;
        rd_chk("R6 mask 0F all locked", A_LOCK, 32'h0F0F_0001);
        loop_locked = 8'h07;
        rd_chk("R6 one masked loop out", A_LOCK, 32'h0F07_0000);
        loop_locked = 8'hF0;
        rd_chk("R6 only unmasked locked", A_LOCK, 32'h0FF0_0000);
        wr(A_LOCK, 32'h0000_0000);
        rd_chk("R6 empty mask", A_LOCK, 32'h00F0_0001);
        loop_locked = 8'hFF;
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(12'h200, 32'hFFFF_FFFF);
        #1 chk("R9 err after write", 32'(bus_err), 32'h1);
        @(negedge clk);
        #1 chk("R9 err one cycle", 32'(bus_err), 32'h0);
        rd(12'h008, v);
        chk("R9 read zero", v, 32'h0);
        #1 chk("R9 err after read", 32'(bus_err), 32'h1);
        rd_chk("R9 cfg_a untouched", A_CFGA, 32'hDEAD_BEEF);
        #1 chk("R9 no err mapped", 32'(bus_err), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read_only();
        t_rw_words();
        t_osc_reads();
        t_cmd_word();
        t_osc_write();
        t_bad_cmds();
        t_lock();
        t_unmapped();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule